// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block watches an asynchronous serial line and rebuilds each character from it. A free-running enable pulses at sixteen times the bit rate. The block finds the start of a character, confirms it half a bit later, and then samples every following bit at its centre. When a character is complete, the block reports the data together with a parity error flag and a framing error flag. In addressed (multiprocessor) format it also reports the extra flag bit that follows the data.

The mode inputs use the same meaning as the matching transmitter controls. They are parity on or off, parity sense, and the addressed format. They are expected to stay fixed while a character is being received. No stop-count input exists. The receiver examines exactly one stop bit in every case, so a two-stop-bit stream and a one-stop-bit stream are received the same way.

Top module: `async_rx_framer`

## Requirements
- R1: After reset, rx_valid, rx_data, par_err, frm_err and mp_bit are all 0.
- R2: A character begins on a high-to-low transition of the line, seen on an os_tick. If the line is high again at the middle of the start bit (the 8th tick), the attempt is dropped and no rx_valid is produced.
- R3: Data bits are taken at the centre of each bit, 16 os_tick per bit, least significant bit first, and rx_data bit 0 is the first data bit received.
- R4: rx_valid is high for exactly one clock per character, in the cycle after the first stop bit is sampled. rx_data, par_err, frm_err and mp_bit hold their values until the next rx_valid.
- R5: With par_en=1, par_odd=0 and mp_mode=0, one parity bit follows the data, and par_err=1 exactly when data plus parity hold an odd number of 1s.
- R6: With par_en=1, par_odd=1 and mp_mode=0, par_err=1 exactly when data plus parity hold an even number of 1s.
- R7: With par_en=0 and mp_mode=0, no bit is expected between the data and the stop bit, and par_err is 0.
- R8: frm_err=1 when the first stop bit is sampled as 0, and the character is still delivered with rx_valid.
- R9: Only the first stop bit is checked. A 0 in the position a second stop bit would occupy is taken as the start bit of the next character, with no framing error on either character.
- R10: With mp_mode=1, one flag bit follows the data and is reported on mp_bit. No parity bit is expected and par_err is 0, whatever par_en and par_odd say. With mp_mode=0, mp_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| mp_mode | input | 1 | Addressed format: flag bit in place of parity |
| rx_data | output | DW | Last received character |
| rx_valid | output | 1 | One-clock strobe per character |
| par_err | output | 1 | Parity mismatch on last character |
| frm_err | output | 1 | First stop bit was 0 on last character |
| mp_bit | output | 1 | Flag bit of last character in addressed format |

## Verification
A bit counter or phase counter that is off by one moves every later sample by a bit. This shows on the very next character as shifted rx_data, a misplaced parity verdict or a spurious framing error, because the stop bit is then read from the wrong slot. A receiver left in a non-idle state after a character either misses the following back-to-back start bit or produces a strobe that nothing was sent for. The scoreboard catches both within one character time, because it treats any strobe arriving with an empty queue as a failure.

// File: rtl/async_rx_framer.sv
module async_rx_framer #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick,
  input  logic          rxd,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          mp_mode,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frm_err,
  output logic          mp_bit
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 1);
  localparam int MID = OVS / 2 - 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_EXTRA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;
  logic          s1, s2, prev, xbit;

  wire cnt_end = (cnt == CW'(OVS - 1));
  wire has_x   = mp_mode | par_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      prev <= 1'b1;
      st <= S_IDLE;
      cnt <= '0;
      bitn <= '0;
      sh <= '0;
      xbit <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      mp_bit <= 1'b0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      rx_valid <= 1'b0;
      if (os_tick) begin
        prev <= s2;
        case (st)
          S_IDLE:
            if (prev && !s2) begin
              st <= S_START;
              cnt <= '0;
            end
          S_START:
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              bitn <= '0;
              st <= s2 ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt_end) begin
              cnt <= '0;
              sh <= {s2, sh[DW-1:1]};
              if (bitn == BW'(DW - 1)) st <= has_x ? S_EXTRA : S_STOP;
              else bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_EXTRA:
            if (cnt_end) begin
              cnt <= '0;
              xbit <= s2;
              st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt_end) begin
              cnt <= '0;
              st <= S_IDLE;
              rx_valid <= 1'b1;
              rx_data <= sh;
              frm_err <= ~s2;
              par_err <= ~mp_mode & par_en & ((^sh) ^ xbit ^ par_odd);
              mp_bit <= mp_mode & xbit;
            end else cnt <= cnt + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R4: strobe lasts one clock
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R4: results change only with the strobe
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data) && $stable(frm_err) && $stable(par_err));
  // R10: addressed format never reports parity errors
  p_mp_no_parerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && mp_mode |-> !par_err);
  // R7: parity off never reports parity errors
  p_nopar_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !par_en |-> !par_err);
  // R3: results are only produced on an oversampling tick
  p_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(os_tick));
endmodule

// File: tb/tb_async_rx_framer.sv
module tb_async_rx_framer;
  localparam int DW = 8;
  localparam int CLK_PER_BIT = 32;

  logic clk = 0, rst_n = 0, os_tick = 0, rxd = 1;
  logic par_en = 0, par_odd = 0, mp_mode = 0;
  logic [DW-1:0] rx_data;
  logic rx_valid, par_err, frm_err, mp_bit;

  int tests = 0, fails = 0, nvalid = 0;
  logic [DW-1:0] q_data[$];
  logic q_pe[$], q_fe[$], q_mp[$];
  string q_tag[$];

  async_rx_framer #(.DW(DW), .OVS(16)) dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_en(par_en), .par_odd(par_odd), .mp_mode(mp_mode),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err),
    .frm_err(frm_err), .mp_bit(mp_bit));

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk) os_tick = 1;
    @(negedge clk) os_tick = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (CLK_PER_BIT) @(negedge clk);
  endtask

  // extra = parity or flag bit value actually sent; stop = first stop value
  task automatic send_frame(input logic [DW-1:0] d, input logic extra,
                            input logic stop, input int high_after, input string tag);
    logic pe;
    pe = !mp_mode && par_en && ((^d) ^ extra ^ par_odd);
    q_data.push_back(d);
    q_pe.push_back(pe);
    q_fe.push_back(!stop);
    q_mp.push_back(mp_mode && extra);
    q_tag.push_back(tag);
    send_bit(1'b0);
    for (int i = 0; i < DW; i++) send_bit(d[i]);
    if (mp_mode || par_en) send_bit(extra);
    send_bit(stop);
    for (int i = 0; i < high_after; i++) send_bit(1'b1);
  endtask

  initial forever begin
    @(posedge clk); #1;
    if (rx_valid) begin
      nvalid++;
      if (q_data.size() == 0) chk(0, "R2 unexpected strobe", 1, 0);
      else begin
        logic [DW-1:0] ed; logic ep, ef, em; string t;
        ed = q_data.pop_front(); ep = q_pe.pop_front();
        ef = q_fe.pop_front(); em = q_mp.pop_front(); t = q_tag.pop_front();
        chk(rx_data == ed, {t, " data"}, rx_data, ed);
        chk(par_err == ep && frm_err == ef && mp_bit == em, {t, " flags pe/fe/mp"},
            {par_err, frm_err, mp_bit}, {ep, ef, em});
        @(posedge clk); #1;
        chk(!rx_valid, "R4 strobe width", rx_valid, 0);
      end
    end
  end

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    chk(!rx_valid && rx_data == 0 && !par_err && !frm_err && !mp_bit,
        "R1 reset state", {rx_valid, par_err, frm_err, mp_bit}, 0);
    rst_n = 1;
    repeat (40) @(negedge clk);
    // R3 R7: no parity, LSB first
    send_frame(8'hA5, 0, 1, 1, "R3 8N1 a5");
    send_frame(8'h01, 0, 1, 1, "R3 8N1 01");
    send_frame(8'h80, 0, 1, 1, "R7 8N1 80");
    // R5 even parity
    par_en = 1;
    send_frame(8'h03, 0, 1, 1, "R5 even good");
    send_frame(8'h07, 0, 1, 1, "R5 even bad");
    // R6 odd parity
    par_odd = 1;
    send_frame(8'h03, 1, 1, 1, "R6 odd good");
    send_frame(8'h03, 0, 1, 1, "R6 odd bad");
    // R10 addressed format ignores parity settings
    mp_mode = 1;
    send_frame(8'h3C, 1, 1, 1, "R10 flag one");
    send_frame(8'h3C, 0, 1, 1, "R10 flag zero");
    mp_mode = 0; par_en = 0; par_odd = 0;
    // R8 framing error, data still delivered
    send_frame(8'h5A, 0, 0, 3, "R8 bad stop");
    // R9 second-stop slot low starts next character
    send_frame(8'hC3, 0, 1, 0, "R9 back to back a");
    send_frame(8'h96, 0, 1, 0, "R9 back to back b");
    send_frame(8'h69, 0, 1, 1, "R9 two stop c");
    send_frame(8'hFF, 0, 1, 2, "R9 two stop d");
    // R2 false start
    n0 = nvalid;
    rxd = 0; repeat (8) @(negedge clk);
    rxd = 1; repeat (3 * CLK_PER_BIT) @(negedge clk);
    chk(nvalid == n0 && q_data.size() == 0, "R2 false start", nvalid - n0, 0);
    send_frame(8'h42, 0, 1, 2, "R2 after glitch");
    repeat (CLK_PER_BIT) @(negedge clk);
    chk(q_data.size() == 0, "R4 all delivered", q_data.size(), 0);
    finish_run();
  end
endmodule